// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management-bus master that reads and writes PHY registers through one 32-bit command/status word. A single write to that word does three things. It loads the PHY address, the register address and the direction. For a write it also loads 16 data bits. It then starts a complete frame on the MDC/MDIO pins. The same word, read back, shows a busy flag while the frame runs. After a read frame it also shows a read-valid flag and the 16-bit result in its low half.

MDC is made from the system clock by a half-period counter set by the parameter `MDC_HALF`. The default of 10 gives 2.5 MHz from a 50 MHz clock. MDC is low while idle. The master changes MDIO only on MDC falling edges. It samples the PHY's read data on MDC rising edges.

Top module: `mdio_master`

## Requirements
- R1: A write (`cmd_we_i`) accepted while busy (bit 28) is 0 starts a frame. Busy then reads 1 from the next cycle for exactly 128*MDC_HALF system cycles. Bits 31:29 always read 0.
- R2: A write presented while busy is 1 is ignored: the readback word and the frame in flight are unchanged.
- R3: Frame order, MSB first: 32 ones, start bits 0 then 1, opcode (1,0 for read, 0,1 for write), PHY address from bits 20:16, register address from bits 25:21, turnaround, then 16 data bits. Bit 26 = 1 selects read and 0 selects write.
- R4: MDC has a period of 2*MDC_HALF system cycles and starts low at the start of each frame. MDIO changes only at the cycle where MDC falls. MDC is low whenever busy is 0.
- R5: In a write frame the output enable is high for all 64 bits, and the turnaround bits are 1,0. In a read frame the enable drops for bit 46 onward (turnaround and data). When idle the enable is low and `mdio_o` is 1.
- R6: In a read frame, `mdio_i` is sampled at each MDC rising edge of bits 48..63, MSB first. At frame end the 16 bits appear in bits 15:0 and read-valid (bit 27) is set.
- R7: A write frame never sets read-valid and leaves its write data in bits 15:0. Every accepted command clears read-valid at once.
- R8: After reset the word reads 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word written |
| cmd_rdata_o | output | 32 | Command/status word read back |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pin input |
| mdio_o | output | 1 | MDIO pin output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
A wrong bit counter or divider shows as a misplaced MDC edge or MDIO bit. The bench compares the pins on every clock, so such a fault is seen in the cycle it first happens. A wrong capture point or shift order stays hidden until the frame ends. It then shows as a wrong low half in the readback word. Lost or stale flags show in the busy and read-valid bits on the first cycle after a command is accepted or refused.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;  // first turnaround bit
  localparam int DATA_BIT   = 48;  // first data bit
  localparam int BUSY_POS   = 28;
  localparam int VALID_POS  = 27;
  localparam int OP_POS     = 26;

  typedef struct packed {
    logic       rd;
    logic [4:0] reg_addr;
    logic [4:0] phy_addr;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01),
            c.phy_addr, c.reg_addr, 2'b10, c.data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(MDC_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(MDC_HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_half_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MDC_HALF));
  a_r4_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [FRAME_BITS-1:0] shreg_q;
  logic [5:0]            bit_q;
  logic                  active_q, rd_q;
  logic [15:0]           cap_q;
  logic                  last_bit;

  assign last_bit  = (bit_q == 6'(FRAME_BITS - 1));
  assign done_o    = active_q && fall_i && last_bit;
  assign active_o  = active_q;
  assign rdata_o   = cap_q;
  assign mdio_o    = active_q ? shreg_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = active_q && !(rd_q && bit_q >= 6'(TA_BIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cap_q    <= '0;
    end else if (start_i) begin
      shreg_q  <= build_frame(cmd_i);
      bit_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= cmd_i.rd;
    end else if (active_q) begin
      if (rise_i && rd_q && bit_q >= 6'(DATA_BIT))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_i) begin
        shreg_q <= shreg_q << 1;
        bit_q   <= bit_q + 1'b1;
        if (last_bit) active_q <= 1'b0;
      end
    end
  end

  a_r4_mdio_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i |-> $stable(mdio_o));
  a_r5_release_ta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && rd_q && bit_q >= 6'(TA_BIT)) |-> !mdio_oe_o);
  a_r1_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  mdio_cmd_t   cmd_q, cmd_new;
  logic        valid_q, busy, start, done, rise, fall;
  logic [15:0] rdata;
  logic        unused_hi;

  assign unused_hi = ^cmd_wdata_i[31:27];
  assign cmd_new   = '{rd: cmd_wdata_i[OP_POS], reg_addr: cmd_wdata_i[25:21],
                       phy_addr: cmd_wdata_i[20:16], data: cmd_wdata_i[15:0]};
  assign start     = cmd_we_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else if (start) begin
      cmd_q   <= cmd_new;
      valid_q <= 1'b0;
    end else if (done && cmd_q.rd) begin
      cmd_q.data <= rdata;
      valid_q    <= 1'b1;
    end
  end

  assign cmd_rdata_o = {3'b000, busy, valid_q, cmd_q};

  mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clkgen (
    .clk_i, .rst_ni, .en_i(busy), .mdc_o, .rise_o(rise), .fall_o(fall));

  mdio_frame u_frame (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd_new), .rise_i(rise),
    .fall_i(fall), .mdc_i(mdc_o), .mdio_i, .active_o(busy), .done_o(done),
    .rdata_o(rdata), .mdio_o, .mdio_oe_o);

  a_r2_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy && !done) |=> $stable({cmd_q.rd, cmd_q.reg_addr, cmd_q.phy_addr}));
  a_r4_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  a_r7_valid_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> cmd_q.rd);
  a_r7_clear_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !valid_q);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int H   = 10;
  localparam int LEN = 128 * H;

  logic clk_i = 1'b0, rst_ni = 1'b0, cmd_we_i = 1'b0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata_i = '0;
  logic [31:0] cmd_rdata_o;
  logic mdc_o, mdio_o, mdio_oe_o;

  mdio_master #(.MDC_HALF(H)) u_mdio_master (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int total = 0, bad = 0, cycles = 0;
  // reference model state (values after latest posedge)
  bit m_busy, m_valid, m_op;
  bit [4:0] m_phy, m_reg;
  bit [15:0] m_data, m_cap, m_resp;
  int m_j;

  function automatic bit frame_bit(int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return m_op;
    if (b == 35) return !m_op;
    if (b <= 40) return m_phy[40-b];
    if (b <= 45) return m_reg[45-b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_data[63-b];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    int b = m_j / (2 * H);
    chk("R1/R6/R7 readback", cmd_rdata_o,
        {3'b000, m_busy, m_valid, m_op, m_reg, m_phy, m_data});
    chk("R4 mdc", {31'd0, mdc_o}, m_busy ? ((m_j / H) % 2) : 0);
    chk("R5 oe", {31'd0, mdio_oe_o}, {31'd0, m_busy && !(m_op && b >= 46)});
    if (!m_busy) chk("R5 idle mdio", {31'd0, mdio_o}, 1);
    else if (mdio_oe_o) chk("R3 frame bit", {31'd0, mdio_o}, {31'd0, frame_bit(b)});
  endtask

  task automatic tick(bit we, bit [31:0] wd);
    int b;
    @(negedge clk_i);
    cycles++;
    compare();
    cmd_we_i = we;
    cmd_wdata_i = wd;
    b = m_j / (2 * H);
    mdio_i = (m_busy && m_op && b >= 48) ? m_resp[63-b] : 1'b1;
    if (we && !m_busy) begin
      m_busy = 1; m_j = 0; m_valid = 0;
      m_op = wd[26]; m_reg = wd[25:21]; m_phy = wd[20:16]; m_data = wd[15:0];
    end else if (m_busy) begin
      m_j++;
      if (m_op && (m_j % (2 * H)) == H && m_j / (2 * H) >= 48)
        m_cap = {m_cap[14:0], mdio_i};
      if (m_j == LEN) begin
        m_busy = 0; m_j = 0;
        if (m_op) begin m_data = m_cap; m_valid = 1; end
      end
    end
  endtask

  task automatic idle_until_done();
    for (int k = 0; k < LEN + 10 && m_busy; k++) tick(0, '0);
    tick(0, '0);
  endtask

  function automatic bit [31:0] cmd(bit rd, bit [4:0] ra, bit [4:0] pa, bit [15:0] d);
    return {5'd0, rd, ra, pa, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: reset state
    tick(0, '0);
    // R1 R3 R5 R7: write frame, with a busy-time write ignored (R2)
    tick(1, cmd(0, 5'd17, 5'd5, 16'hA5C3));
    repeat (200) tick(0, '0);
    tick(1, cmd(1, 5'd2, 5'd9, 16'h0000));  // R2 ignored
    idle_until_done();
    // R6: read, with high junk bits set (R1 bits 31:29 read zero)
    m_resp = 16'h1234;
    tick(1, 32'hF800_0000 | cmd(1, 5'd0, 5'd31, 16'hBEEF));
    idle_until_done();
    // R7: new write clears valid, back to back after completion
    tick(1, cmd(0, 5'd31, 5'd0, 16'h0F0F));
    for (int k = 0; k < LEN - 1; k++) tick(0, '0);
    tick(1, cmd(1, 5'd31, 5'd0, 16'h0));  // arrives on last busy cycle: R2
    m_resp = 16'hFFFF;
    tick(1, cmd(1, 5'd31, 5'd0, 16'h0));
    idle_until_done();
    m_resp = 16'h8001;
    tick(1, cmd(1, 5'd10, 5'd21, 16'h5555));
    idle_until_done();
    repeat (5) tick(0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule